// File: doc/BRIEF.md
# Clock Synthesizer Startup Reset Sequencer

This block starts an on-chip clock synthesizer once device configuration has finished, and then keeps the user logic in reset until that synthesizer says its output is stable. It runs entirely on the raw reference clock, because the synthesized clock cannot be trusted while the block is at work. When the configuration-done level rises, a single token goes into a chain of flops. That token sets both how long the block waits before resetting the synthesizer and how long the reset pulse lasts. The end of the chain drives the synthesizer reset. The same last stage also stops any further ones from entering, so the pulse happens once and the block then goes quiet.

After the pulse, the block synchronizes the lock flag into the reference domain and combines it with the external system reset. The result is a run-enable for a consumer clock domain. That enable drops at once, without waiting for a clock edge, when either condition fails. It returns only after a short synchronizer in the consumer domain. A 3-bit phase output shows where the sequence stands. The system reset also acts as the block's own power-up reset, and a new configuration-done rise after it starts a fresh sequence.

Top module: `startup_rst_seq`

## Requirements
- R1: While `sys_rst` is high, `synth_rst` is 0, `user_rst_n` is 0 and `phase` reads 0 (waiting for done).
- R2: `phase` encodes 0 = waiting for done, 1 = delay, 2 = synthesizer in reset, 3 = waiting for lock, 4 = running. It only moves forward through this order until `sys_rst` or a lock loss.
- R3: After `cfg_done` rises, `phase` turns 1 on the third following reference-clock edge. This covers a two-flop synchronizer plus an edge register. `phase` stays 1 for exactly 16 cycles. While `cfg_done` is low, `phase` stays 0.
- R4: `synth_rst` goes high as `phase` leaves 1 and stays high for exactly 16 reference cycles. During that time `phase` reads 2. After that, `synth_rst` never rises again until `sys_rst`.
- R5: `user_rst_n` stays 0 until the synthesizer reset pulse has ended, even when `synth_lock` has been high the whole time.
- R6: `user_rst_n` rises on the third consumer-clock edge after `phase` first reads 4. `phase` reads 4 on the second reference edge after `synth_lock` rises, provided the pulse is over.
- R7: If `synth_lock` falls while running, `phase` reads 3 two edges later and `user_rst_n` is 0 one edge after that. No new `synth_rst` pulse follows. When lock returns, release follows R6.
- R8: Once a sequence has started, a fall and a new rise of `cfg_done` has no effect on `synth_rst` or `phase`.
- R9: Raising `sys_rst` drives `user_rst_n` to 0 and `phase` to 0 at once, without waiting for a clock edge.
- R10: If `synth_lock` is low when the pulse ends, `phase` reads 3 and `user_rst_n` stays 0 for as long as lock stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Raw reference clock; clocks the sequencer |
| user_clk | input | 1 | Consumer-domain clock for the release synchronizer |
| sys_rst | input | 1 | Active-high system reset, asynchronous |
| cfg_done | input | 1 | Configuration-finished level, asynchronous |
| synth_lock | input | 1 | Lock flag from the clock synthesizer, asynchronous |
| synth_rst | output | 1 | Reset pulse to the clock synthesizer |
| user_rst_n | output | 1 | Active-low reset for user logic; 1 means run |
| phase | output | 3 | Sequence phase, encoded as in R2 |

## Verification
Each round changes the idle time before `cfg_done` rises. This separates a sequence that starts from the done edge from one that starts from the release of reset. The lock flag comes in three forms. It can be high from the start, which shows whether lock is wrongly used before the pulse ends. It can rise right at the end of the pulse or after a random gap, which shows whether release is tied to lock rather than to a fixed delay. Later in some rounds the lock drops and returns, and `cfg_done` toggles again. These show that a lost lock takes away the release without a second synthesizer pulse, and that the sequence cannot be started twice.

// File: rtl/startup_rst_seq_pkg.sv
package startup_rst_seq_pkg;
  typedef enum logic [2:0] {
    PH_WAIT_DONE = 3'd0,
    PH_DELAY     = 3'd1,
    PH_RESETTING = 3'd2,
    PH_WAIT_LOCK = 3'd3,
    PH_RUNNING   = 3'd4
  } phase_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '0;
    else      chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srs_token_chain.sv
module srs_token_chain #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic arst,
  input  logic arm,
  output logic armed,
  output logic fired,
  output logic pulse
);
  localparam int CW = $clog2(DEPTH + 1) + 1;

  logic [DEPTH-1:0] stage;
  logic             feed;

  // Ones enter while armed, until the last stage shows the first one;
  // after that a zero follows and the fired flag blocks any refill.
  assign feed  = armed & ~fired & ~stage[DEPTH-1];
  assign pulse = stage[DEPTH-1];

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      armed <= 1'b0;
      fired <= 1'b0;
    end else begin
      armed <= armed | arm;
      fired <= fired | stage[DEPTH-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk or posedge arst) begin
          if (arst) stage[0] <= 1'b0;
          else      stage[0] <= feed;
        end
      end else begin : g_body
        always_ff @(posedge clk or posedge arst) begin
          if (arst) stage[g] <= 1'b0;
          else      stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  // Pulse width monitor
  logic [CW-1:0] width_cnt;
  always_ff @(posedge clk or posedge arst) begin
    if (arst)       width_cnt <= '0;
    else if (pulse) width_cnt <= width_cnt + 1'b1;
  end

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (arst)
    width_cnt <= CW'(DEPTH));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (arst)
    $rose(pulse) |-> !fired);

  p_no_pulse_unarmed_r3: assert property (@(posedge clk) disable iff (arst)
    pulse |-> armed);
endmodule

// File: rtl/srs_release.sv
module srs_release #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic run,
  output logic rst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge run) begin
    if (!run) chain <= '0;
    else      chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/startup_rst_seq.sv
module startup_rst_seq #(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int REL_STAGES  = 2
) (
  input  logic       ref_clk,
  input  logic       user_clk,
  input  logic       sys_rst,
  input  logic       cfg_done,
  input  logic       synth_lock,
  output logic       synth_rst,
  output logic       user_rst_n,
  output logic [2:0] phase
);
  import startup_rst_seq_pkg::*;

  logic   done_s, done_q, arm;
  logic   lock_s;
  logic   armed, fired, pulse;
  logic   run_q;
  phase_e ph;

  srs_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(ref_clk), .arst(sys_rst), .d(cfg_done), .q(done_s));

  srs_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk(ref_clk), .arst(sys_rst), .d(synth_lock), .q(lock_s));

  always_ff @(posedge ref_clk or posedge sys_rst) begin
    if (sys_rst) done_q <= 1'b0;
    else         done_q <= done_s;
  end

  assign arm = done_s & ~done_q;

  srs_token_chain #(.DEPTH(DEPTH)) u_chain (
    .clk(ref_clk), .arst(sys_rst), .arm(arm),
    .armed(armed), .fired(fired), .pulse(pulse));

  assign synth_rst = pulse;

  always_comb begin
    if (!armed)      ph = PH_WAIT_DONE;
    else if (pulse)  ph = PH_RESETTING;
    else if (!fired) ph = PH_DELAY;
    else if (lock_s) ph = PH_RUNNING;
    else             ph = PH_WAIT_LOCK;
  end

  assign phase = ph;

  always_ff @(posedge ref_clk or posedge sys_rst) begin
    if (sys_rst) run_q <= 1'b0;
    else         run_q <= (ph == PH_RUNNING);
  end

  srs_release #(.STAGES(REL_STAGES)) u_release (
    .clk(user_clk), .run(run_q), .rst_n(user_rst_n));

  p_release_after_pulse_r5: assert property (@(posedge ref_clk) disable iff (sys_rst)
    user_rst_n |-> fired);

  p_hold_during_pulse_r5: assert property (@(posedge ref_clk) disable iff (sys_rst)
    synth_rst |-> !user_rst_n);

  p_wait_order_r2: assert property (@(posedge ref_clk) disable iff (sys_rst)
    (ph == PH_WAIT_DONE) |=> (ph == PH_WAIT_DONE || ph == PH_DELAY));

  p_reset_order_r2: assert property (@(posedge ref_clk) disable iff (sys_rst)
    (ph == PH_RESETTING) |=> (ph == PH_RESETTING || ph == PH_WAIT_LOCK || ph == PH_RUNNING));

  p_no_regen_r7: assert property (@(posedge ref_clk) disable iff (sys_rst)
    (ph == PH_WAIT_LOCK) |=> !synth_rst);
endmodule

// File: tb/startup_rst_seq_tb_top.sv
module startup_rst_seq_tb_top;
  logic clk = 1'b0;
  logic sys_rst = 1'b1;
  logic cfg_done = 1'b0;
  logic synth_lock = 1'b0;
  logic synth_rst, user_rst_n;
  logic [2:0] phase;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  localparam int DEPTH = 16;
  localparam int SYNC  = 2;
  localparam int REL   = 2;

  always #10 clk = ~clk;

  startup_rst_seq dut_i (
    .ref_clk(clk), .user_clk(clk), .sys_rst(sys_rst), .cfg_done(cfg_done),
    .synth_lock(synth_lock), .synth_rst(synth_rst), .user_rst_n(user_rst_n),
    .phase(phase));

  function automatic int done_to_delay();   return SYNC + 1; endfunction
  function automatic int lock_to_run();     return SYNC;     endfunction
  function automatic int run_to_release();  return REL + 1;  endfunction
  function automatic int lock_loss_to_rst(); return SYNC + 1; endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_release();
    for (int i = 1; i < run_to_release(); i++) begin
      tick();
      chk("R6 held before release", user_rst_n, 0);
    end
    tick();
    chk("R6 release", user_rst_n, 1);
  endtask

  task automatic round(bit early, int gap, bit retog, bit dropl);
    int n;
    bit ok;
    @(negedge clk);
    sys_rst = 1'b1; cfg_done = 1'b0; synth_lock = early;
    repeat (3) tick();
    chk("R1 phase", phase, 0);
    chk("R1 synth_rst", synth_rst, 0);
    chk("R1 user_rst_n", user_rst_n, 0);
    sys_rst = 1'b0;
    n = $urandom_range(1, 12);
    repeat (n) tick();
    chk("R3 idle without done", phase, 0);
    cfg_done = 1'b1;
    for (int i = 1; i < done_to_delay(); i++) begin
      tick();
      chk("R3 before delay", phase, 0);
    end
    tick();
    chk("R3 delay entry", phase, 1);
    n = 0;
    while (phase == 3'd1 && n < 40) begin tick(); n++; end
    chk("R3 delay length", n, DEPTH);
    chk("R4 phase resetting", phase, 2);
    n = 0; ok = 1'b1;
    while (synth_rst && n < 40) begin
      if (user_rst_n !== 1'b0 || phase != 3'd2) ok = 1'b0;
      tick(); n++;
    end
    chk("R4 pulse width", n, DEPTH);
    chk("R5 held during pulse", ok, 1);
    chk("R5 phase after pulse", phase, early ? 4 : 3);
    if (!early) begin
      ok = 1'b1;
      for (int i = 0; i < gap; i++) begin
        tick();
        if (phase != 3'd3 || user_rst_n !== 1'b0) ok = 1'b0;
      end
      chk("R10 waiting for lock", ok, 1);
      synth_lock = 1'b1;
      for (int i = 1; i < lock_to_run(); i++) begin
        tick();
        chk("R6 lock not yet seen", phase, 3);
      end
      tick();
      chk("R6 running", phase, 4);
    end
    expect_release();
    if (retog) begin
      cfg_done = 1'b0;
      repeat ($urandom_range(3, 8)) tick();
      cfg_done = 1'b1;
      ok = 1'b1;
      repeat (30) begin
        tick();
        if (synth_rst || phase != 3'd4 || !user_rst_n) ok = 1'b0;
      end
      chk("R8 done retoggle ignored", ok, 1);
    end
    if (dropl) begin
      synth_lock = 1'b0;
      for (int i = 1; i < lock_loss_to_rst(); i++) tick();
      chk("R7 phase after lock loss", phase, 3);
      tick();
      chk("R7 reset after lock loss", user_rst_n, 0);
      ok = 1'b1;
      repeat (30) begin tick(); if (synth_rst || user_rst_n) ok = 1'b0; end
      chk("R7 no new pulse", ok, 1);
      synth_lock = 1'b1;
      for (int i = 0; i < lock_to_run(); i++) tick();
      chk("R7 running again", phase, 4);
      expect_release();
    end
    @(negedge clk);
    sys_rst = 1'b1;
    #1;
    chk("R9 async user reset", user_rst_n, 0);
    chk("R9 phase cleared", phase, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    round(1'b1, 0, 1'b1, 1'b1);
    round(1'b0, 0, 1'b0, 1'b0);
    round(1'b0, 25, 1'b1, 1'b1);
    for (int r = 0; r < 8; r++)
      round(1'($urandom_range(0, 1)), $urandom_range(0, 30),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule